// File: doc/BRIEF.md
# Switch-Mode Drive Pulse Sequencer

This block produces one drive pulse per horizontal line for a switching supply stage, such as a boost converter that regulates its current or a buck converter that sets its pulse width from a timing capacitor. It is a set/reset state machine in a single clock domain. A rising edge on the line-drive input starts each line. Three comparator flags come from the analog side: the sense level is above the error level, the sense level is below the restart threshold, and the sense level has reached the stop (floor) level. These flags end the pulse, mark the end of a capacitor discharge, and re-arm the drive. The drive output is active low. A second output enables the capacitor discharge path in buck mode.

If a line passes without a comparator reset, the next line edge forces the pulse off. The pulse then waits for the restart flag before it turns on again. In buck mode the capacitor is discharged during that wait, so the ratio of charge current to discharge current sets the maximum duty cycle. A global enable holds everything off and returns the machine to idle.

States: IDLE (disabled or waiting for the first edge), DRIVE (pulse on), OFF (boost: pulse ended by the comparator, waiting for the next edge), DISCH (buck: pulse ended by the comparator, discharging), HOLD (buck: stop level reached, discharge held), RECOV (pulse forced off, waiting for the restart flag). Transitions: IDLE→DRIVE on an edge. DRIVE→OFF or DRIVE→DISCH on the comparator trip, depending on mode. DISCH→HOLD on the stop flag. OFF, DISCH or HOLD→DRIVE on an edge. DRIVE or RECOV→RECOV on an edge with no trip in the line. RECOV→DRIVE on the restart flag. Any state→IDLE when enable is low.

Top module: `swdrv_seq`

## Requirements
- R1: While `en` is low, `drv_n` is 1 and `dis_en` is 0 in the same cycle. The machine goes to IDLE, and after `en` returns it needs a line edge before it drives again. Reset gives the same output state.
- R2: A rising edge of `line_in` in IDLE, or after a line in which the comparator tripped, turns the pulse on (`drv_n` = 0). The edge is found by comparing `line_in` with its value one clock earlier, and `drv_n` falls one clock after the edge is sampled.
- R3: In boost mode (`mode_buck` = 0), `sense_hi` during the pulse turns it off (`drv_n` = 1) until the next line edge, and `dis_en` stays 0 throughout. Comparator flags act two clocks after they are sampled, because of the synchronisers.
- R4: A rising line edge while the pulse is still on, meaning no comparator trip occurred in that line, forces the pulse off.
- R5: After a forced turn-off, `sense_low` turns the pulse on again without waiting for a line edge.
- R6: In buck mode (`mode_buck` = 1), `sense_hi` during the pulse turns it off and raises `dis_en`. `dis_en` stays 1 after `sense_floor` is reached, until the next line edge.
- R7: In buck mode, a line edge after a comparator trip turns the pulse on and drops `dis_en`, whether or not the stop level was reached first.
- R8: In buck mode, a forced turn-off raises `dis_en` with `drv_n` = 1. `sense_low` then drops `dis_en` and turns the pulse on in the same cycle. `drv_n` = 0 and `dis_en` = 1 never occur together.
- R9: `sense_hi` has no effect outside the pulse, and `sense_low` has no effect outside the forced-off wait.
- R10: When a line edge and the comparator trip reach the machine in the same clock, the edge wins and the pulse is forced off (R4 path).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable |
| mode_buck | input | 1 | 0 = boost feedback, 1 = buck feed-forward |
| line_in | input | 1 | Line-drive pulse, synchronous to clk |
| sense_hi | input | 1 | Comparator: sense above error level (asynchronous) |
| sense_low | input | 1 | Comparator: sense below restart threshold (asynchronous) |
| sense_floor | input | 1 | Comparator: sense at stop level (asynchronous) |
| drv_n | output | 1 | Drive pulse, active low |
| dis_en | output | 1 | Discharge enable |

## Verification
Boost lines are run with a comparator trip, which separates a comparator turn-off from a forced one. They are also run without a trip, which exposes the forced turn-off and the restart path. Buck lines are run with the trip followed by the stop flag, with the trip alone before an early edge, and with no trip. Together these separate discharge hold, early re-arm and duty-cycle limiting. Stray comparator flags in the wrong states, and a trip that coincides with a line edge, expose priority and state-gating faults. A long run with random flags and mode switches is compared against a behavioural model on every clock.

// File: rtl/swdrv_pkg.sv
package swdrv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DRIVE,
        ST_OFF,
        ST_DISCH,
        ST_HOLD,
        ST_RECOV
    } seq_state_t;

    localparam int FLAG_W = 3;
    localparam int FLAG_HI    = 2;
    localparam int FLAG_LOW   = 1;
    localparam int FLAG_FLOOR = 0;
endpackage

// File: rtl/swdrv_sync.sv
module swdrv_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/swdrv_line_track.sv
module swdrv_line_track (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic line_in,
    input  logic trip_seen,
    output logic line_rise,
    output logic had_reset
);
    logic line_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= 1'b0;
        else        line_q <= line_in;
    end

    assign line_rise = line_in & ~line_q;

    // per-line record of a comparator reset; line edge clears it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 had_reset <= 1'b0;
        else if (!en || line_rise)  had_reset <= 1'b0;
        else if (trip_seen)         had_reset <= 1'b1;
    end
endmodule

// File: rtl/swdrv_fsm.sv
module swdrv_fsm
    import swdrv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic mode_buck,
    input  logic line_rise,
    input  logic had_reset,
    input  logic trip,
    input  logic restart,
    input  logic at_floor,
    output logic trip_seen,
    output logic drv_n,
    output logic dis_en
);
    seq_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_IDLE;
        end else if (line_rise) begin
            if (state_q == ST_IDLE || had_reset) state_d = ST_DRIVE;
            else                                 state_d = ST_RECOV;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_DRIVE: if (trip) state_d = mode_buck ? ST_DISCH : ST_OFF;
                ST_OFF:   state_d = ST_OFF;
                ST_DISCH: if (at_floor) state_d = ST_HOLD;
                ST_HOLD:  state_d = ST_HOLD;
                ST_RECOV: if (restart) state_d = ST_DRIVE;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        drv_n     = 1'b1;
        dis_en    = 1'b0;
        trip_seen = 1'b0;
        unique case (state_q)
            ST_DRIVE: begin
                drv_n     = ~en;
                trip_seen = trip;
            end
            ST_DISCH, ST_HOLD, ST_RECOV: dis_en = en & mode_buck;
            ST_IDLE, ST_OFF: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/swdrv_seq.sv
module swdrv_seq
    import swdrv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic mode_buck,
    input  logic line_in,
    input  logic sense_hi,
    input  logic sense_low,
    input  logic sense_floor,
    output logic drv_n,
    output logic dis_en
);
    logic [FLAG_W-1:0] flags_raw, flags_s;
    logic line_rise, had_reset, trip_seen;

    assign flags_raw[FLAG_HI]    = sense_hi;
    assign flags_raw[FLAG_LOW]   = sense_low;
    assign flags_raw[FLAG_FLOOR] = sense_floor;

    swdrv_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (flags_raw),
        .q     (flags_s)
    );

    swdrv_line_track u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .line_in   (line_in),
        .trip_seen (trip_seen),
        .line_rise (line_rise),
        .had_reset (had_reset)
    );

    swdrv_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .mode_buck (mode_buck),
        .line_rise (line_rise),
        .had_reset (had_reset),
        .trip      (flags_s[FLAG_HI]),
        .restart   (flags_s[FLAG_LOW]),
        .at_floor  (flags_s[FLAG_FLOOR]),
        .trip_seen (trip_seen),
        .drv_n     (drv_n),
        .dis_en    (dis_en)
    );
endmodule

// File: rtl/swdrv_seq_chk.sv
module swdrv_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic mode_buck,
    input logic line_in,
    input logic drv_n,
    input logic dis_en
);
    // R1
    enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (drv_n && !dis_en));

    // R3
    boost_no_dis_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_buck |-> !dis_en);

    // R8
    drive_dis_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!drv_n && dis_en));

    // R4
    forced_off_chk: assert property (@(posedge clk) disable iff (!rst_n || !en)
        (line_in && !$past(line_in) && !drv_n) |=> drv_n);
endmodule

bind swdrv_seq swdrv_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .mode_buck (mode_buck),
    .line_in   (line_in),
    .drv_n     (drv_n),
    .dis_en    (dis_en)
);

// File: tb/tb_swdrv_seq.sv
`timescale 1ns/1ps
module tb_swdrv_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, mode_buck = 1'b0, line_in = 1'b0;
    logic sense_hi = 1'b0, sense_low = 1'b0, sense_floor = 1'b0;
    logic drv_n, dis_en;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    swdrv_seq dut (
        .clk(clk), .rst_n(rst_n), .en(en), .mode_buck(mode_buck),
        .line_in(line_in), .sense_hi(sense_hi), .sense_low(sense_low),
        .sense_floor(sense_floor), .drv_n(drv_n), .dis_en(dis_en)
    );

    // behavioural reference: 0 idle,1 drive,2 off,3 disch,4 hold,5 recov
    int m_st = 0;
    bit m_flag = 0, m_prev = 0, m_rise;
    bit [2:0] m_pipe[$] = '{3'b000, 3'b000};
    bit [2:0] m_s;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_flag = 0; m_prev = 0;
            m_pipe = '{3'b000, 3'b000};
        end else begin
            m_s = m_pipe.pop_front();
            m_pipe.push_back({sense_hi, sense_low, sense_floor});
            m_rise = line_in && !m_prev;
            m_prev = line_in;
            if (!en) begin
                m_st = 0; m_flag = 0;
            end else if (m_rise) begin
                m_st = (m_st == 0 || m_flag) ? 1 : 5;
                m_flag = 0;
            end else if (m_st == 1 && m_s[2]) begin
                m_flag = 1;
                m_st = mode_buck ? 3 : 2;
            end else if (m_st == 3 && m_s[0]) begin
                m_st = 4;
            end else if (m_st == 5 && m_s[1]) begin
                m_st = 1;
            end
        end
    end

    always @(negedge clk) begin
        logic ed, es;
        ed = !(en && m_st == 1);
        es = en && mode_buck && (m_st >= 3);
        vectors++;
        if (drv_n !== ed || dis_en !== es) begin
            fails++;
            $display("FAIL %s: model compare drv_n=%b dis_en=%b expected %b %b at %0t",
                     cur_req, drv_n, dis_en, ed, es, $time);
        end
    end

    task automatic chk(input string req, input logic ed, input logic es);
        vectors++;
        if (drv_n !== ed || dis_en !== es) begin
            fails++;
            $display("FAIL %s: drv_n=%b dis_en=%b expected %b %b at %0t",
                     req, drv_n, dis_en, ed, es, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic line_edge();
        line_in = 1'b1; cyc(3); line_in = 1'b0;
    endtask

    task automatic trip_pulse();
        sense_hi = 1'b1; cyc(2); sense_hi = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL R1: watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        #3; chk("R1", 1, 0);                    // reset state
        cyc(3); rst_n = 1'b1; cyc(2);
        // R1: disabled, stimulus ignored
        line_edge(); sense_hi = 1; sense_low = 1; cyc(6);
        @(negedge clk); chk("R1", 1, 0);
        sense_hi = 0; sense_low = 0;

        // boost
        cur_req = "R2"; en = 1; mode_buck = 0; cyc(3);
        line_edge(); cyc(3); @(negedge clk); chk("R2", 0, 0);
        cur_req = "R3"; trip_pulse(); cyc(5); @(negedge clk); chk("R3", 1, 0);
        cur_req = "R9"; sense_low = 1; cyc(6); @(negedge clk); chk("R9", 1, 0);
        sense_low = 0; cyc(3);
        cur_req = "R2"; line_edge(); cyc(5); @(negedge clk); chk("R2", 0, 0);
        cur_req = "R4"; line_edge(); cyc(5); @(negedge clk); chk("R4", 1, 0);
        cur_req = "R9"; trip_pulse(); cyc(5); @(negedge clk); chk("R9", 1, 0);
        cur_req = "R5"; sense_low = 1; cyc(5); @(negedge clk); chk("R5", 0, 0);
        sense_low = 0; cyc(4);

        // R10: edge and trip arrive together
        cur_req = "R10";
        sense_hi = 1; cyc(2); line_in = 1; cyc(1); sense_hi = 0; cyc(2); line_in = 0;
        cyc(5); @(negedge clk); chk("R10", 1, 0);
        sense_low = 1; cyc(5); @(negedge clk); chk("R10", 0, 0);
        sense_low = 0; cyc(4);

        // buck
        cur_req = "R6"; mode_buck = 1; cyc(2); @(negedge clk); chk("R6", 0, 0);
        trip_pulse(); cyc(5); @(negedge clk); chk("R6", 1, 1);
        sense_floor = 1; cyc(5); @(negedge clk); chk("R6", 1, 1);
        cur_req = "R9"; sense_low = 1; cyc(5); @(negedge clk); chk("R9", 1, 1);
        sense_low = 0; sense_floor = 0; cyc(3);
        cur_req = "R7"; line_edge(); cyc(5); @(negedge clk); chk("R7", 0, 0);
        trip_pulse(); cyc(5); @(negedge clk); chk("R6", 1, 1);
        line_edge(); cyc(5); @(negedge clk); chk("R7", 0, 0);
        cur_req = "R8"; line_edge(); cyc(5); @(negedge clk); chk("R8", 1, 1);
        sense_low = 1; cyc(5); @(negedge clk); chk("R8", 0, 0);
        sense_low = 0; cyc(3);

        // enable drop mid-pulse
        cur_req = "R1"; en = 0; @(negedge clk); chk("R1", 1, 0);
        cyc(3); en = 1; cyc(5); @(negedge clk); chk("R1", 1, 0);
        cur_req = "R2"; line_edge(); cyc(5); @(negedge clk); chk("R2", 0, 0);

        // random traffic, compared on every clock
        for (int i = 0; i < 6000; i++) begin
            if (i % 500 == 0) mode_buck = $urandom_range(0, 1);
            cur_req = mode_buck ? "R6" : "R3";
            line_in = ((i % 37) < 3);
            sense_hi = ($urandom_range(0, 15) == 0);
            sense_low = ($urandom_range(0, 7) == 0);
            sense_floor = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 299) == 0) en = ~en;
            cyc(1);
        end
        en = 1; cyc(5);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule